// File: doc/BRIEF.md
# NAND Block Erase and Identification Sequencer

This block drives the command, address and data strobes of an 8-bit NAND flash bus for two short operations. The first is a block erase. The block number is turned into a row address by shifting it left by the number of page-address bits: 4 for devices with 16 pages per block, 5 for devices with 32 pages per block. The row address is then sent between an erase-setup command and an erase-confirm command. The second operation reads the identification bytes. After the identify command and one zero address byte, the block waits a fixed settle time. It then reads two bytes: the maker code first and the device code second.

A host starts an operation with a one-cycle pulse and waits for the done pulse. Every bus cycle lasts one clock. During that clock exactly one of the write or read strobes is high, and the command-latch or address-latch line qualifies it. The settle delay is computed from two parameters, the settle time and the clock period, both in picoseconds. The block does not wait for the erase to finish, and it does not read device status.

Top module: `nand_erase_id_seq`

## Requirements
- R1: An erase (opSel=0) puts out four write cycles in consecutive clocks. The first comes in the clock after start. In order they are: command 0x60, row address low byte, row address high byte, command 0xD0.
- R2: With pages32=0 the row address is blockNum shifted left by 4. Only its low 16 bits are sent.
- R3: With pages32=1 the row address is blockNum shifted left by 5. Only its low 16 bits are sent.
- R4: An identification read (opSel=1) puts out command 0x90 in the clock after start. In the next clock it puts out one address byte of 0x00.
- R5: Between the identification address cycle and the first read cycle there are exactly SETTLE_CYC clocks with no strobe. SETTLE_CYC is SETTLE_PS divided by CLK_PERIOD_PS, rounded up, with a minimum of 1. The defaults give 5.
- R6: Two read cycles follow in consecutive clocks. busIn sampled in the first goes to makerId. busIn sampled in the second goes to deviceId.
- R7: cmdLatch and addrLatch are never high together. Every write cycle has exactly one of them high. A read cycle has neither of them high.
- R8: done is high for exactly one clock, the clock right after the last strobe of an operation, and it has no strobe in it.
- R9: makerId and deviceId change only through an identification read. An erase leaves them unchanged.
- R10: A start pulse that arrives while an operation is running is ignored, together with its opSel, blockNum and pages32.
- R11: After reset all strobes and latch lines are low, done is low, and makerId and deviceId are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin an operation |
| opSel | input | 1 | 0 = block erase, 1 = identification read |
| blockNum | input | BLOCK_W | Block to erase |
| pages32 | input | 1 | 0 = 16 pages per block, 1 = 32 pages per block |
| cmdLatch | output | 1 | Command latch enable |
| addrLatch | output | 1 | Address latch enable |
| wrStb | output | 1 | Write cycle: busOut is valid and driven |
| rdStb | output | 1 | Read cycle: busIn is sampled at the end of the clock |
| busOut | output | 8 | Byte driven to the flash |
| busIn | input | 8 | Byte returned by the flash |
| makerId | output | 8 | Captured maker code |
| deviceId | output | 8 | Captured device code |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench runs erases with the same block number in both page modes. This shows that the shift amount follows pages32. It also runs a block number with all bits set in 32-page mode, which shows that the top row bit is dropped. Identification reads are run with two different pairs of codes, and in each pair the maker and device bytes differ. This catches a swap of the two bytes, and it shows that the captured values are replaced by the next identification read and left alone by an erase. Each expected bus cycle also records how many idle clocks should come before it, so the settle gap and the placement of the done pulse are checked. A second start pulse sent in the middle of a sequence must produce no extra bus cycles.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    BUS_ZERO,
    BUS_ERASE_SETUP,
    BUS_ERASE_GO,
    BUS_READ_ID,
    BUS_ROW_LO,
    BUS_ROW_HI
  } busSel_e;

  typedef struct packed {
    logic    loadRow;
    busSel_e busSel;
    logic    capMaker;
    logic    capDevice;
  } seqCtl_t;

  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_READ_ID     = 8'h90;

endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    opSel,
  output seqCtl_t ctl,
  output logic    cmdLatch,
  output logic    addrLatch,
  output logic    wrStb,
  output logic    rdStb,
  output logic    done
);

  localparam int CNT_W = $clog2(SETTLE_CYC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_E_SETUP, S_E_ADR0, S_E_ADR1, S_E_GO,
    S_I_CMD, S_I_ADR, S_I_WAIT, S_I_RD0, S_I_RD1, S_DONE
  } state_e;

  state_e state, nextState;
  logic [CNT_W-1:0] waitCnt;

  always_comb begin
    nextState = state;
    case (state)
      S_IDLE:    if (start) nextState = opSel ? S_I_CMD : S_E_SETUP;
      S_E_SETUP: nextState = S_E_ADR0;
      S_E_ADR0:  nextState = S_E_ADR1;
      S_E_ADR1:  nextState = S_E_GO;
      S_E_GO:    nextState = S_DONE;
      S_I_CMD:   nextState = S_I_ADR;
      S_I_ADR:   nextState = S_I_WAIT;
      S_I_WAIT:  if (waitCnt == CNT_W'(SETTLE_CYC - 1)) nextState = S_I_RD0;
      S_I_RD0:   nextState = S_I_RD1;
      S_I_RD1:   nextState = S_DONE;
      default:   nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
    end else begin
      state <= nextState;
      if (state == S_I_WAIT) waitCnt <= waitCnt + 1'b1;
      else                   waitCnt <= '0;
    end
  end

  always_comb begin
    ctl       = '{loadRow: 1'b0, busSel: BUS_ZERO, capMaker: 1'b0, capDevice: 1'b0};
    cmdLatch  = 1'b0;
    addrLatch = 1'b0;
    wrStb     = 1'b0;
    rdStb     = 1'b0;
    done      = 1'b0;
    case (state)
      S_IDLE:    ctl.loadRow = start && !opSel;
      S_E_SETUP: begin cmdLatch  = 1'b1; wrStb = 1'b1; ctl.busSel = BUS_ERASE_SETUP; end
      S_E_ADR0:  begin addrLatch = 1'b1; wrStb = 1'b1; ctl.busSel = BUS_ROW_LO; end
      S_E_ADR1:  begin addrLatch = 1'b1; wrStb = 1'b1; ctl.busSel = BUS_ROW_HI; end
      S_E_GO:    begin cmdLatch  = 1'b1; wrStb = 1'b1; ctl.busSel = BUS_ERASE_GO; end
      S_I_CMD:   begin cmdLatch  = 1'b1; wrStb = 1'b1; ctl.busSel = BUS_READ_ID; end
      S_I_ADR:   begin addrLatch = 1'b1; wrStb = 1'b1; ctl.busSel = BUS_ZERO; end
      S_I_RD0:   begin rdStb = 1'b1; ctl.capMaker  = 1'b1; end
      S_I_RD1:   begin rdStb = 1'b1; ctl.capDevice = 1'b1; end
      S_DONE:    done = 1'b1;
      default:   ;
    endcase
  end

endmodule

// File: rtl/nand_seq_dpath.sv
module nand_seq_dpath
  import nand_seq_pkg::*;
#(
  parameter int BLOCK_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqCtl_t            ctl,
  input  logic [BLOCK_W-1:0] blockNum,
  input  logic               pages32,
  input  logic [7:0]         busIn,
  output logic [7:0]         busOut,
  output logic [7:0]         makerId,
  output logic [7:0]         deviceId
);

  localparam int ADDR_BYTES = 2;
  localparam int ROW_W      = 8 * ADDR_BYTES;
  localparam int WIDE_W     = BLOCK_W + 5;

  logic [WIDE_W-1:0] wideRow;
  logic [ROW_W-1:0]  rowAddr;

  always_comb begin
    if (pages32) wideRow = {blockNum, 5'b0};
    else         wideRow = {1'b0, blockNum, 4'b0};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowAddr  <= '0;
      makerId  <= '0;
      deviceId <= '0;
    end else begin
      if (ctl.loadRow)   rowAddr  <= ROW_W'(wideRow);
      if (ctl.capMaker)  makerId  <= busIn;
      if (ctl.capDevice) deviceId <= busIn;
    end
  end

  always_comb begin
    case (ctl.busSel)
      BUS_ERASE_SETUP: busOut = OP_ERASE_SETUP;
      BUS_ERASE_GO:    busOut = OP_ERASE_GO;
      BUS_READ_ID:     busOut = OP_READ_ID;
      BUS_ROW_LO:      busOut = rowAddr[7:0];
      BUS_ROW_HI:      busOut = rowAddr[15:8];
      default:         busOut = 8'h00;
    endcase
  end

endmodule

// File: rtl/nand_erase_id_seq.sv
module nand_erase_id_seq
  import nand_seq_pkg::*;
#(
  parameter int BLOCK_W       = 12,
  parameter int CLK_PERIOD_PS = 20000,
  parameter int SETTLE_PS     = 100000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               opSel,
  input  logic [BLOCK_W-1:0] blockNum,
  input  logic               pages32,
  output logic               cmdLatch,
  output logic               addrLatch,
  output logic               wrStb,
  output logic               rdStb,
  output logic [7:0]         busOut,
  input  logic [7:0]         busIn,
  output logic [7:0]         makerId,
  output logic [7:0]         deviceId,
  output logic               done
);

  localparam int SETTLE_RAW = (SETTLE_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;

  seqCtl_t ctl;

  nand_seq_ctrl #(.SETTLE_CYC(SETTLE_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .ctl(ctl),
    .cmdLatch(cmdLatch), .addrLatch(addrLatch), .wrStb(wrStb),
    .rdStb(rdStb), .done(done)
  );

  nand_seq_dpath #(.BLOCK_W(BLOCK_W)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .blockNum(blockNum),
    .pages32(pages32), .busIn(busIn), .busOut(busOut),
    .makerId(makerId), .deviceId(deviceId)
  );

endmodule

// File: rtl/nand_seq_checker.sv
module nand_seq_checker #(
  parameter int SETTLE_CYC = 5
) (
  input logic       clk,
  input logic       rstN,
  input logic       cmdLatch,
  input logic       addrLatch,
  input logic       wrStb,
  input logic       rdStb,
  input logic [7:0] busOut,
  input logic [7:0] makerId,
  input logic [7:0] deviceId,
  input logic       done
);

  localparam int CNT_W = $clog2(SETTLE_CYC + 2) + 1;
  logic [CNT_W-1:0] quietCnt;

  always_ff @(posedge clk) begin
    if (!rstN) quietCnt <= '0;
    else if (wrStb || rdStb) quietCnt <= '0;
    else if (quietCnt != '1) quietCnt <= quietCnt + 1'b1;
  end

  assert_latch_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdLatch && addrLatch));

  assert_wr_qualified_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |-> (cmdLatch ^ addrLatch));

  assert_rd_unlatched_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdStb |-> (!cmdLatch && !addrLatch && !wrStb));

  assert_done_after_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!wrStb && !rdStb && $past(wrStb || rdStb)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_settle_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && !$past(rdStb)) |-> (quietCnt == CNT_W'(SETTLE_CYC)));

  assert_confirm_order_R1: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && cmdLatch && busOut == 8'hD0) |-> $past(wrStb && addrLatch));

  assert_id_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |=> ($stable(makerId) && $stable(deviceId)));

endmodule

bind nand_erase_id_seq nand_seq_checker #(.SETTLE_CYC(SETTLE_CYC)) chk_i (
  .clk(clk), .rstN(rstN), .cmdLatch(cmdLatch), .addrLatch(addrLatch),
  .wrStb(wrStb), .rdStb(rdStb), .busOut(busOut), .makerId(makerId),
  .deviceId(deviceId), .done(done)
);

// File: tb/nand_erase_id_seq_tb_top.sv
module nand_erase_id_seq_tb_top;

  localparam int BLOCK_W = 12;
  localparam int SETTLE  = 5;
  localparam logic [1:0] EV_CMD = 2'd0, EV_ADR = 2'd1, EV_RD = 2'd2, EV_DONE = 2'd3;

  typedef struct packed {
    logic [1:0] kind;
    logic [7:0] data;
    logic [7:0] gap;
    logic [3:0] req;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic opSel = 1'b0;
  logic [BLOCK_W-1:0] blockNum = '0;
  logic pages32 = 1'b0;
  logic cmdLatch, addrLatch, wrStb, rdStb, done;
  logic [7:0] busOut, makerId, deviceId;
  logic [7:0] busIn;
  logic [7:0] chipMaker = 8'h00;
  logic [7:0] chipDevice = 8'h00;
  int rdIdx = 0;

  int errors = 0;
  int checks = 0;
  int gapCnt = 0;
  int cycles = 0;
  bit seenDone = 1'b0;
  bit firstItem = 1'b0;
  item_t expQ[$];

  always #10 clk = ~clk;

  assign busIn = (rdIdx == 0) ? chipMaker : chipDevice;
  always @(posedge clk) if (rdStb) rdIdx <= rdIdx + 1;

  nand_erase_id_seq dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .blockNum(blockNum),
    .pages32(pages32), .cmdLatch(cmdLatch), .addrLatch(addrLatch), .wrStb(wrStb),
    .rdStb(rdStb), .busOut(busOut), .busIn(busIn), .makerId(makerId),
    .deviceId(deviceId), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] kind, input logic [7:0] data,
                      input logic [7:0] gap, input logic [3:0] req);
    item_t it;
    it.kind = kind; it.data = data; it.gap = gap; it.req = req;
    expQ.push_back(it);
  endtask

  // Monitor: compare every bus event against the scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      cycles++;
      if (wrStb || rdStb || done) begin
        logic [1:0] kind;
        kind = done ? EV_DONE : rdStb ? EV_RD : (cmdLatch ? EV_CMD : EV_ADR);
        if (expQ.size() == 0) begin
          check(1'b0, "R10 unexpected bus event", kind, 4'hF);
        end else begin
          item_t it;
          it = expQ.pop_front();
          check(kind == it.kind, $sformatf("R%0d event kind", it.req), kind, it.kind);
          if (kind == EV_CMD || kind == EV_ADR)
            check(busOut == it.data, $sformatf("R%0d bus byte", it.req), busOut, it.data);
          if (!firstItem && it.gap != 8'hFF)
            check(gapCnt == it.gap, $sformatf("R%0d idle gap", it.req), gapCnt, it.gap);
        end
        if (done) seenDone = 1'b1;
        firstItem = 1'b0;
        gapCnt = 0;
      end else begin
        gapCnt++;
      end
    end
  end

  // Driver: queue the expected events then pulse start
  task automatic runOp(input bit id, input logic [BLOCK_W-1:0] blk, input bit p32,
                       input bit pokeBusy);
    logic [16:0] wide;
    logic [15:0] row;
    wide = p32 ? {blk, 5'b0} : {1'b0, blk, 4'b0};
    row = wide[15:0];
    if (id) begin
      push(EV_CMD, 8'h90, 8'hFF, 4'd4);         // R4 identify command
      push(EV_ADR, 8'h00, 8'd0, 4'd4);          // R4 zero address
      push(EV_RD, 8'h00, 8'(SETTLE), 4'd5);     // R5 settle gap
      push(EV_RD, 8'h00, 8'd0, 4'd6);           // R6 second read
      push(EV_DONE, 8'h00, 8'd0, 4'd8);         // R8 done right after
    end else begin
      push(EV_CMD, 8'h60, 8'hFF, 4'd1);         // R1 setup
      push(EV_ADR, row[7:0], 8'd0, p32 ? 4'd3 : 4'd2);
      push(EV_ADR, row[15:8], 8'd0, p32 ? 4'd3 : 4'd2);
      push(EV_CMD, 8'hD0, 8'd0, 4'd1);          // R1 confirm
      push(EV_DONE, 8'h00, 8'd0, 4'd8);
    end
    @(negedge clk);
    rdIdx = 0;
    seenDone = 1'b0;
    firstItem = 1'b1;
    opSel = id; blockNum = blk; pages32 = p32; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (pokeBusy) begin
      @(negedge clk);
      opSel = ~id; blockNum = ~blk; pages32 = ~p32; start = 1'b1;  // R10
      @(negedge clk);
      start = 1'b0;
    end
    while (!seenDone && cycles < 100000) @(negedge clk);
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R10 sequence completeness", expQ.size(), 0);
    expQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check({cmdLatch, addrLatch, wrStb, rdStb, done} == 5'b0, "R11 strobes low",
          {cmdLatch, addrLatch, wrStb, rdStb, done}, 0);
    check(makerId == 8'h00 && deviceId == 8'h00, "R11 ids zero",
          {makerId, deviceId}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runOp(1'b0, 12'h123, 1'b0, 1'b0);   // R2 16-page erase
    runOp(1'b0, 12'h123, 1'b1, 1'b0);   // R3 32-page erase
    runOp(1'b0, 12'hFFF, 1'b1, 1'b0);   // R3 top bit dropped

    chipMaker = 8'hEC; chipDevice = 8'h75;
    runOp(1'b1, '0, 1'b0, 1'b0);
    check(makerId == 8'hEC, "R6 maker byte", makerId, 8'hEC);
    check(deviceId == 8'h75, "R6 device byte", deviceId, 8'h75);

    chipMaker = 8'h11; chipDevice = 8'h22;
    runOp(1'b0, 12'h0A5, 1'b0, 1'b1);   // R10 busy start ignored
    check(makerId == 8'hEC && deviceId == 8'h75, "R9 erase keeps ids",
          {makerId, deviceId}, 16'hEC75);

    chipMaker = 8'h98; chipDevice = 8'hE6;
    runOp(1'b1, '0, 1'b1, 1'b1);        // R10 busy start during ID read
    check(makerId == 8'h98, "R9 maker replaced", makerId, 8'h98);
    check(deviceId == 8'hE6, "R9 device replaced", deviceId, 8'hE6);

    if (cycles >= 100000) check(1'b0, "watchdog", cycles, 100000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule